// File: doc/BRIEF.md
# Fuse-Driven Boot Source Sequencer

This block decides how a chip leaves reset. It reads three things: a 64-bit boot-policy fuse word delivered as two 32-bit halves, a 32-bit auxiliary fuse word, and an external pin that requests the serial download loader. A one-cycle `start` pulse captures all of them at once. From then on the sequence runs only on the captured copy.

The block then does one of two things. It may park in loader mode. Otherwise it probes the flash sources one at a time, either the external flash, the internal flash, or external first with internal as a fallback. Each probe is a single-cycle request carrying a source code. The block then waits, for any number of cycles, for a pass or fail reply from the flash-probe logic.

The sequence ends in one of three held states: loader, booted (with the source that passed), or failed (a sticky error). The block also drives three configuration flags decoded from the captured fuses: firmware decryption enable, digest-check enable and fast-clock enable. Flash access, decryption and hashing are done elsewhere.

Top module: `boot_seq_top`

## Requirements
- R1: A `start` pulse while idle captures both policy halves (`fuse_b_lo_i` as bits 31..0, `fuse_b_hi_i` as bits 63..32), the auxiliary word and the loader pin. Changes to these inputs after that cycle do not affect the sequence or the flags.
- R2: Loader entry is permitted when policy bit 7 is clear or auxiliary bit 1 is set. If the captured pin is high and entry is permitted, `loader_mode_o` rises and no probe request is ever issued.
- R3: With policy bit 62 set, the first probe uses source code 0 (external). After a fail reply, exactly one further probe uses code 1 (internal).
- R4: With policy bit 62 clear, exactly one probe is issued. Its code is 0 when policy bit 61 is set and 1 when bit 61 is clear.
- R5: Each probe request is high for exactly one cycle, with `probe_sel_o` valid in that cycle. The block waits with no time limit for a reply.
- R6: A pass reply sets `boot_ok_o`, with `boot_src_o` equal to the code of the source that passed. No further requests follow.
- R7: When every permitted source has replied fail, `boot_err_o` rises and stays high until reset.
- R8: A pass and a fail reply in the same cycle count as a pass.
- R9: After capture, `decrypt_en_o` is the inverse of policy bit 8, `digest_chk_en_o` equals policy bit 9, and `fast_clk_o` equals policy bit 63. All three are low in reset.
- R10: `start` is ignored while a sequence runs or after it has ended. The end state holds until reset.
- R11: After reset, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle pulse that begins the sequence |
| fuse_b_lo_i | input | 32 | Boot-policy fuse word, bits 31..0 |
| fuse_b_hi_i | input | 32 | Boot-policy fuse word, bits 63..32 |
| fuse_a_i | input | 32 | Auxiliary fuse word |
| loader_pin_i | input | 1 | External request for loader mode |
| probe_ok_i | input | 1 | One-cycle pass reply from flash probe |
| probe_fail_i | input | 1 | One-cycle fail reply from flash probe |
| probe_req_o | output | 1 | One-cycle probe request |
| probe_sel_o | output | 1 | Source code: 0 external, 1 internal |
| busy_o | output | 1 | Sequence in progress |
| loader_mode_o | output | 1 | Held in loader mode |
| boot_ok_o | output | 1 | A flash source passed |
| boot_src_o | output | 1 | Code of the source that passed |
| boot_err_o | output | 1 | Sticky: all permitted sources failed |
| decrypt_en_o | output | 1 | Firmware decryption enable |
| digest_chk_en_o | output | 1 | Firmware digest check enable |
| fast_clk_o | output | 1 | Fast boot clock enable |

## Verification
Two pairs of events can land on the same clock edge. The first is a pass and a fail reply arriving together. The second is a fresh `start` pulse arriving while a probe reply is pending. A directed run with a single external source drives both replies in one cycle, and raises `start` during the wait. It is judged by the block ending in the booted state with code 0, after exactly one request. The main sweep covers every combination of the loader-permission bits, the pin, the two order bits and the per-source replies. It changes the fuse inputs right after capture, and it checks the request count, the codes, the outcome and the flags against a model computed in the bench.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECIDE,
        ST_REQ,
        ST_WAIT,
        ST_LOADER,
        ST_DONE,
        ST_FAIL
    } seq_state_e;

    localparam logic SRC_EXT = 1'b0;
    localparam logic SRC_INT = 1'b1;

    typedef struct packed {
        logic loader_ok;
        logic first_src;
        logic has_fallback;
    } boot_plan_t;

endpackage

// File: rtl/fuse_capture.sv
module fuse_capture #(
    parameter int FUSE_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cap_en_i,
    input  logic [FUSE_W-1:0]   fuse_b_lo_i,
    input  logic [FUSE_W-1:0]   fuse_b_hi_i,
    input  logic [FUSE_W-1:0]   fuse_a_i,
    input  logic                loader_pin_i,
    output logic [2*FUSE_W-1:0] fuse_b_o,
    output logic [FUSE_W-1:0]   fuse_a_o,
    output logic                pin_o,
    output logic                valid_o
);
    localparam int B_W = 2 * FUSE_W;

    typedef struct packed {
        logic [B_W-1:0]    b;
        logic [FUSE_W-1:0] a;
        logic              pin;
        logic              valid;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (cap_en_i) begin
            cap_d.b     = {fuse_b_hi_i, fuse_b_lo_i};
            cap_d.a     = fuse_a_i;
            cap_d.pin   = loader_pin_i;
            cap_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign fuse_b_o = cap_q.b;
    assign fuse_a_o = cap_q.a;
    assign pin_o    = cap_q.pin;
    assign valid_o  = cap_q.valid;
endmodule

// File: rtl/fuse_decode.sv
module fuse_decode
    import boot_seq_pkg::*;
#(
    parameter int FUSE_W       = 32,
    parameter int LOCK_BIT     = 7,
    parameter int NODECRYPT_BIT = 8,
    parameter int DIGEST_BIT   = 9,
    parameter int ONLY_EXT_BIT = 61,
    parameter int FALLBACK_BIT = 62,
    parameter int FAST_BIT     = 63,
    parameter int OVERRIDE_BIT = 1
) (
    input  logic [2*FUSE_W-1:0] fuse_b_i,
    input  logic [FUSE_W-1:0]   fuse_a_i,
    input  logic                valid_i,
    output boot_plan_t          plan_o,
    output logic                decrypt_en_o,
    output logic                digest_chk_en_o,
    output logic                fast_clk_o
);
    always_comb begin
        plan_o.loader_ok    = !fuse_b_i[LOCK_BIT] || fuse_a_i[OVERRIDE_BIT];
        plan_o.has_fallback = fuse_b_i[FALLBACK_BIT];
        if (fuse_b_i[FALLBACK_BIT])
            plan_o.first_src = SRC_EXT;
        else
            plan_o.first_src = fuse_b_i[ONLY_EXT_BIT] ? SRC_EXT : SRC_INT;
        decrypt_en_o    = valid_i && !fuse_b_i[NODECRYPT_BIT];
        digest_chk_en_o = valid_i && fuse_b_i[DIGEST_BIT];
        fast_clk_o      = valid_i && fuse_b_i[FAST_BIT];
    end
endmodule

// File: rtl/boot_seq_fsm.sv
module boot_seq_fsm
    import boot_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       pin_i,
    input  boot_plan_t plan_i,
    input  logic       probe_ok_i,
    input  logic       probe_fail_i,
    output logic       cap_en_o,
    output logic       probe_req_o,
    output logic       probe_sel_o,
    output logic       busy_o,
    output logic       loader_mode_o,
    output logic       boot_ok_o,
    output logic       boot_src_o,
    output logic       boot_err_o
);
    typedef struct packed {
        seq_state_e state;
        logic       cur_src;
        logic       ok;
        logic       src;
        logic       err;
        logic       loader;
    } fsm_t;

    fsm_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.state)
            ST_IDLE: begin
                if (start_i) s_d.state = ST_DECIDE;
            end
            ST_DECIDE: begin
                if (pin_i && plan_i.loader_ok) begin
                    s_d.state  = ST_LOADER;
                    s_d.loader = 1'b1;
                end else begin
                    s_d.state   = ST_REQ;
                    s_d.cur_src = plan_i.first_src;
                end
            end
            ST_REQ: begin
                s_d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (probe_ok_i) begin
                    s_d.state = ST_DONE;
                    s_d.ok    = 1'b1;
                    s_d.src   = s_q.cur_src;
                end else if (probe_fail_i) begin
                    if (plan_i.has_fallback && s_q.cur_src == SRC_EXT) begin
                        s_d.state   = ST_REQ;
                        s_d.cur_src = SRC_INT;
                    end else begin
                        s_d.state = ST_FAIL;
                        s_d.err   = 1'b1;
                    end
                end
            end
            ST_LOADER, ST_DONE, ST_FAIL: begin
                s_d.state = s_q.state;
            end
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{state: ST_IDLE, default: '0};
        else        s_q <= s_d;
    end

    assign cap_en_o      = (s_q.state == ST_IDLE) && start_i;
    assign probe_req_o   = (s_q.state == ST_REQ);
    assign probe_sel_o   = (s_q.state == ST_REQ) && s_q.cur_src;
    assign busy_o        = (s_q.state == ST_DECIDE) || (s_q.state == ST_REQ) ||
                           (s_q.state == ST_WAIT);
    assign loader_mode_o = s_q.loader;
    assign boot_ok_o     = s_q.ok;
    assign boot_src_o    = s_q.src;
    assign boot_err_o    = s_q.err;
endmodule

// File: rtl/boot_seq_top.sv
module boot_seq_top
    import boot_seq_pkg::*;
#(
    parameter int FUSE_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [FUSE_W-1:0] fuse_b_lo_i,
    input  logic [FUSE_W-1:0] fuse_b_hi_i,
    input  logic [FUSE_W-1:0] fuse_a_i,
    input  logic              loader_pin_i,
    input  logic              probe_ok_i,
    input  logic              probe_fail_i,
    output logic              probe_req_o,
    output logic              probe_sel_o,
    output logic              busy_o,
    output logic              loader_mode_o,
    output logic              boot_ok_o,
    output logic              boot_src_o,
    output logic              boot_err_o,
    output logic              decrypt_en_o,
    output logic              digest_chk_en_o,
    output logic              fast_clk_o
);
    localparam int B_W = 2 * FUSE_W;

    logic              cap_en;
    logic [B_W-1:0]    fuse_b_q;
    logic [FUSE_W-1:0] fuse_a_q;
    logic              pin_q;
    logic              cap_valid;
    boot_plan_t        plan;

    fuse_capture #(.FUSE_W(FUSE_W)) cap_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cap_en_i     (cap_en),
        .fuse_b_lo_i  (fuse_b_lo_i),
        .fuse_b_hi_i  (fuse_b_hi_i),
        .fuse_a_i     (fuse_a_i),
        .loader_pin_i (loader_pin_i),
        .fuse_b_o     (fuse_b_q),
        .fuse_a_o     (fuse_a_q),
        .pin_o        (pin_q),
        .valid_o      (cap_valid)
    );

    fuse_decode #(.FUSE_W(FUSE_W)) dec_i (
        .fuse_b_i        (fuse_b_q),
        .fuse_a_i        (fuse_a_q),
        .valid_i         (cap_valid),
        .plan_o          (plan),
        .decrypt_en_o    (decrypt_en_o),
        .digest_chk_en_o (digest_chk_en_o),
        .fast_clk_o      (fast_clk_o)
    );

    boot_seq_fsm fsm_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .pin_i         (pin_q),
        .plan_i        (plan),
        .probe_ok_i    (probe_ok_i),
        .probe_fail_i  (probe_fail_i),
        .cap_en_o      (cap_en),
        .probe_req_o   (probe_req_o),
        .probe_sel_o   (probe_sel_o),
        .busy_o        (busy_o),
        .loader_mode_o (loader_mode_o),
        .boot_ok_o     (boot_ok_o),
        .boot_src_o    (boot_src_o),
        .boot_err_o    (boot_err_o)
    );
endmodule

// File: rtl/boot_seq_chk.sv
module boot_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic probe_req_o,
    input logic busy_o,
    input logic loader_mode_o,
    input logic boot_ok_o,
    input logic boot_src_o,
    input logic boot_err_o
);
    p_req_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        probe_req_o |=> !probe_req_o);

    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        boot_err_o |=> boot_err_o);

    p_loader_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        loader_mode_o |-> !probe_req_o);

    p_one_outcome_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({loader_mode_o, boot_ok_o, boot_err_o}));

    p_ok_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        boot_ok_o |=> (boot_ok_o && $stable(boot_src_o)));

    p_end_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (loader_mode_o || boot_ok_o || boot_err_o) |=> !busy_o);
endmodule

bind boot_seq_top boot_seq_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .probe_req_o   (probe_req_o),
    .busy_o        (busy_o),
    .loader_mode_o (loader_mode_o),
    .boot_ok_o     (boot_ok_o),
    .boot_src_o    (boot_src_o),
    .boot_err_o    (boot_err_o)
);

// File: tb/boot_seq_tb.sv
module boot_seq_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] b_lo = '0, b_hi = '0, fa = '0;
    logic        pin = 1'b0, p_ok = 1'b0, p_fail = 1'b0;
    logic        req, sel, busy, ldr, bok, bsrc, berr, dec, dig, fast;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    boot_seq_top dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .fuse_b_lo_i(b_lo), .fuse_b_hi_i(b_hi), .fuse_a_i(fa),
        .loader_pin_i(pin), .probe_ok_i(p_ok), .probe_fail_i(p_fail),
        .probe_req_o(req), .probe_sel_o(sel), .busy_o(busy),
        .loader_mode_o(ldr), .boot_ok_o(bok), .boot_src_o(bsrc),
        .boot_err_o(berr), .decrypt_en_o(dec), .digest_chk_en_o(dig),
        .fast_clk_o(fast)
    );

    task automatic chk(input bit cond, input string rq, input int act, input int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; start = 0; p_ok = 0; p_fail = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        // R11: all outputs low after reset
        chk({req, sel, busy, ldr, bok, bsrc, berr, dec, dig, fast} == '0, "R11",
            int'({req, sel, busy, ldr, bok, bsrc, berr, dec, dig, fast}), 0);
    endtask

    // One full sequence. resp bit0: external passes, bit1: internal passes.
    task automatic run_case(input bit b7, a1, pn, b62, b61, b8, b9, b63,
                            input logic [1:0] resp, input int dly, input bit both);
        bit     allow, exp_ldr, exp_ok, exp_src;
        int     exp_att, att, n;
        logic   s0;
        allow   = !b7 || a1;
        exp_ldr = pn && allow;
        if (exp_ldr) begin
            exp_att = 0; exp_ok = 0; exp_src = 0;
        end else if (b62) begin
            if (resp[0]) begin exp_att = 1; exp_ok = 1; exp_src = 0; end
            else begin exp_att = 2; exp_ok = resp[1]; exp_src = 1; end
        end else begin
            s0 = b61 ? 1'b0 : 1'b1;
            exp_att = 1; exp_ok = both ? 1'b1 : resp[s0]; exp_src = s0;
        end

        do_reset();
        b_lo = 32'h5A5A_A000; b_hi = 32'h0F0F_0000; fa = 32'hC3C3_0000;
        b_lo[7] = b7; b_lo[8] = b8; b_lo[9] = b9;
        b_hi[29] = b61; b_hi[30] = b62; b_hi[31] = b63;
        fa[1] = a1; pin = pn; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R1: disturb all captured inputs right after capture
        b_lo = ~b_lo; b_hi = ~b_hi; fa = ~fa; pin = ~pin;

        att = 0; n = 0;
        while (!(ldr || bok || berr) && n < 60) begin
            if (req) begin
                logic es;
                es = b62 ? ((att == 0) ? 1'b0 : 1'b1) : (b61 ? 1'b0 : 1'b1);
                chk(sel == es, b62 ? "R3 sel" : "R4 sel", sel, es);
                att++;
                repeat (1 + dly) @(negedge clk);
                if (both) begin
                    start = 1'b1; // R10: ignored while busy
                    p_ok = 1'b1; p_fail = 1'b1;
                end else begin
                    p_ok = resp[sel === 1'bx ? 0 : es];
                    p_fail = !resp[es];
                end
                @(negedge clk);
                p_ok = 0; p_fail = 0; start = 0;
            end else begin
                @(negedge clk);
            end
            n++;
        end

        chk(att == exp_att, b62 ? "R3 count" : (exp_ldr ? "R2 count" : "R4 count"), att, exp_att);
        chk(ldr == exp_ldr, "R2 loader", ldr, exp_ldr);
        if (!exp_ldr) begin
            chk(bok == exp_ok, both ? "R8 pass wins" : "R6 ok", bok, exp_ok);
            chk(berr == !exp_ok, "R7 err", berr, !exp_ok);
            if (exp_ok) chk(bsrc == exp_src, "R6 src", bsrc, exp_src);
        end
        chk(dec == !b8, "R9 decrypt", dec, !b8);
        chk(dig == b9,  "R9 digest", dig, b9);
        chk(fast == b63, "R9 fast", fast, b63);

        // R10 / R7: start after the end changes nothing, error stays
        begin
            logic [3:0] snap;
            int rq;
            snap = {ldr, bok, bsrc, berr};
            rq = 0;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (4) begin
                if (req) rq++;
                @(negedge clk);
            end
            chk(rq == 0 && {ldr, bok, bsrc, berr} == snap && !busy, "R10 hold",
                int'({ldr, bok, bsrc, berr}), int'(snap));
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 128; i++) begin
            run_case(i[0], i[1], i[2], i[3], i[4],
                     i[0] ^ i[3], i[1] ^ i[4], i[2] ^ i[5],
                     {i[6], i[5]}, i % 3, 1'b0);
        end
        // R8: both replies in one cycle, single external source, start raised meanwhile
        run_case(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 2'b00, 2, 1'b1);
        // R5: long wait before reply, fallback path, external fails
        run_case(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2'b10, 20, 1'b0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule